// File: doc/BRIEF.md
# Folded Constant-Geometry Radix-2 FFT Core

This block computes an 8-point complex discrete Fourier transform on 16-bit two's-complement samples. It uses a radix-2 factorization in which every stage is wired the same way. Only one stage datapath exists in hardware. A working register feeds that stage's result back to its input, so the stage runs log2(N) times. Each pass reads operand pairs through a fixed stride permutation, with element k paired with element k+N/2. It then scales every operand by a twiddle factor chosen by pass number and position. Then N/2 butterflies produce sum and difference, and these are written to adjacent positions 2k and 2k+1.

A multiplexer sits in front of the stage. On the first pass it takes the external input vector. On every later pass it takes the working register. After the last pass, one more clock edge copies the working register into an output register and raises a one-cycle completion strobe. The result stays in the output register until the next transform finishes. The output is left in bit-reversed order, and there is no scaling between passes.

A consumer loads a whole vector in parallel, pulses start, waits for the strobe and reads the whole vector back.

Top module: `fft_cg_core`

## Requirements
- R1: While reset is high and on the first cycle after it, done is low and both output vectors are all zero.
- R2: A start accepted on a rising edge makes done high for exactly one cycle. That cycle follows the fourth rising edge, counting the accepting edge as the first (log2(N) passes plus one output edge). Done is low at all other times.
- R3: While a transform is in progress, start is ignored. A new input vector presented after acceptance has no effect on the timing or on the result of the running transform.
- R4: The outputs change only on the edge that raises done. They hold their value on every cycle where done is low.
- R5: Output lane p (bits [16p+15:16p]) holds bin X[k] of X[k] = sum over n of x[n]*exp(-j*2*pi*n*k/8), with no scaling. Here k is p with its three bits reversed, so bit 0 of p becomes bit 2 of k. For input magnitudes up to 1800, each real and imaginary part is within 8 LSB of the exact value.
- R6: A start asserted in the cycle where done is high is accepted, and the next transform completes four edges later with its own correct result.
- R7: An impulse of amplitude A (|A| up to 16000) at input lane 0, with zero imaginary parts, gives exactly A in every real output lane and exactly 0 in every imaginary lane. Unity twiddles and quarter-turn twiddles introduce no rounding on this path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transform on the presented vector; sampled only when idle |
| din_re | input | N*DW | Real parts of the input vector, lane p at bits [p*DW +: DW] |
| din_im | input | N*DW | Imaginary parts of the input vector, same lane layout |
| done | output | 1 | One-cycle strobe when a new result is in the output register |
| dout_re | output | N*DW | Real parts of the result, bit-reversed bin order |
| dout_im | output | N*DW | Imaginary parts of the result, bit-reversed bin order |

## Verification
The bench compares every lane against a direct DFT of the same samples, computed in floating point. A lane-0 impulse must give an exactly flat spectrum. This separates a correct pass sequence from one that rounds on unity twiddles. Impulses at other lanes, a constant vector, a single cosine at bin 1, an alternating-sign vector and several hundred random vectors exercise every twiddle and every permutation path. These patterns expose a wrong twiddle exponent, a swapped butterfly output or a wrong lane order. Other sequences keep start high while a transform runs, with a different vector on the inputs, and chain transforms back to back from the done cycle. They check that the running result cannot be disturbed and that the strobe timing and output hold are right.

// File: rtl/fft_cg_pkg.sv
package fft_cg_pkg;

  // Quantized twiddle W_n^e = exp(-j*2*pi*e/n), scaled to 2^(dw-1)-1, rounded.
  function automatic int tw_q(input int e, input int n, input int dw, input bit imag_part);
    real ang;
    real v;
    real s;
    ang = 6.283185307179586 * real'(e) / real'(n);
    v   = imag_part ? -$sin(ang) : $cos(ang);
    s   = v * real'((1 << (dw - 1)) - 1);
    return (s >= 0.0) ? $rtoi(s + 0.5) : $rtoi(s - 0.5);
  endfunction

endpackage

// File: rtl/cg_twiddle_rom.sv
module cg_twiddle_rom #(
  parameter int N  = 8,
  parameter int DW = 16,
  parameter int CW = 2
) (
  input  logic [CW-1:0]   pass,
  output logic [N*DW-1:0] w_re,
  output logic [N*DW-1:0] w_im
);
  import fft_cg_pkg::*;

  localparam int HALF = N / 2;
  localparam int EW   = $clog2(HALF);
  localparam logic signed [DW-1:0] ONE = DW'((1 << (DW - 1)) - 1);

  logic signed [DW-1:0] tab_re [HALF];
  logic signed [DW-1:0] tab_im [HALF];

  for (genvar g = 0; g < HALF; g++) begin : g_tab
    assign tab_re[g] = DW'(tw_q(g, N, DW, 1'b0));
    assign tab_im[g] = DW'(tw_q(g, N, DW, 1'b1));
  end

  // Odd lanes carry the difference outputs of the previous pass and take its
  // deferred twiddle; even lanes and the first pass are unity.
  for (genvar p = 0; p < N; p++) begin : g_lane
    if ((p % 2) == 0) begin : g_even
      assign w_re[p*DW +: DW] = ONE;
      assign w_im[p*DW +: DW] = '0;
    end else begin : g_odd
      localparam int K = (p - 1) / 2;
      logic [EW-1:0] expo;
      always_comb begin
        if (pass == '0) expo = '0;
        else            expo = EW'((K >> (pass - 1'b1)) << (pass - 1'b1));
      end
      assign w_re[p*DW +: DW] = tab_re[expo];
      assign w_im[p*DW +: DW] = tab_im[expo];
    end
  end

endmodule

// File: rtl/cg_cmul.sv
module cg_cmul #(
  parameter int DW = 16
) (
  input  logic signed [DW-1:0] a_re,
  input  logic signed [DW-1:0] a_im,
  input  logic signed [DW-1:0] w_re,
  input  logic signed [DW-1:0] w_im,
  output logic signed [DW-1:0] y_re,
  output logic signed [DW-1:0] y_im
);
  localparam int PW = 2 * DW + 1;
  localparam logic signed [DW-1:0] ONE = DW'((1 << (DW - 1)) - 1);
  localparam logic signed [PW-1:0] RND = PW'(1) <<< (DW - 2);

  logic signed [PW-1:0] pr, pi;
  logic unit;
  logic unused_bits;

  assign unit = (w_re == ONE) && (w_im == '0);
  assign pr = PW'(a_re) * PW'(w_re) - PW'(a_im) * PW'(w_im) + RND;
  assign pi = PW'(a_re) * PW'(w_im) + PW'(a_im) * PW'(w_re) + RND;

  assign y_re = unit ? a_re : pr[2*DW-2 -: DW];
  assign y_im = unit ? a_im : pi[2*DW-2 -: DW];

  assign unused_bits = ^{pr[PW-1 -: 2], pr[DW-2:0], pi[PW-1 -: 2], pi[DW-2:0]};

endmodule

// File: rtl/cg_bfly.sv
module cg_bfly #(
  parameter int DW = 16
) (
  input  logic signed [DW-1:0] a_re,
  input  logic signed [DW-1:0] a_im,
  input  logic signed [DW-1:0] b_re,
  input  logic signed [DW-1:0] b_im,
  output logic signed [DW-1:0] s_re,
  output logic signed [DW-1:0] s_im,
  output logic signed [DW-1:0] d_re,
  output logic signed [DW-1:0] d_im
);
  assign s_re = a_re + b_re;
  assign s_im = a_im + b_im;
  assign d_re = a_re - b_re;
  assign d_im = a_im - b_im;
endmodule

// File: rtl/cg_stage.sv
module cg_stage #(
  parameter int N  = 8,
  parameter int DW = 16,
  parameter int CW = 2
) (
  input  logic [CW-1:0]   pass,
  input  logic [N*DW-1:0] x_re,
  input  logic [N*DW-1:0] x_im,
  output logic [N*DW-1:0] y_re,
  output logic [N*DW-1:0] y_im
);
  localparam int HALF = N / 2;

  logic [N*DW-1:0] w_re, w_im;
  logic [N*DW-1:0] t_re, t_im;

  cg_twiddle_rom #(.N(N), .DW(DW), .CW(CW)) u_rom (
    .pass (pass),
    .w_re (w_re),
    .w_im (w_im)
  );

  for (genvar p = 0; p < N; p++) begin : g_scale
    cg_cmul #(.DW(DW)) u_mul (
      .a_re (x_re[p*DW +: DW]),
      .a_im (x_im[p*DW +: DW]),
      .w_re (w_re[p*DW +: DW]),
      .w_im (w_im[p*DW +: DW]),
      .y_re (t_re[p*DW +: DW]),
      .y_im (t_im[p*DW +: DW])
    );
  end

  // Fixed stride permutation: lanes k and k+N/2 meet, results land at 2k, 2k+1.
  for (genvar k = 0; k < HALF; k++) begin : g_pair
    cg_bfly #(.DW(DW)) u_bf (
      .a_re (t_re[k*DW +: DW]),
      .a_im (t_im[k*DW +: DW]),
      .b_re (t_re[(k+HALF)*DW +: DW]),
      .b_im (t_im[(k+HALF)*DW +: DW]),
      .s_re (y_re[(2*k)*DW +: DW]),
      .s_im (y_im[(2*k)*DW +: DW]),
      .d_re (y_re[(2*k+1)*DW +: DW]),
      .d_im (y_im[(2*k+1)*DW +: DW])
    );
  end

endmodule

// File: rtl/fft_cg_core.sv
module fft_cg_core #(
  parameter int N  = 8,
  parameter int DW = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [N*DW-1:0] din_re,
  input  logic [N*DW-1:0] din_im,
  output logic            done,
  output logic [N*DW-1:0] dout_re,
  output logic [N*DW-1:0] dout_im
);
  localparam int NPASS = $clog2(N);
  localparam int CW    = $clog2(NPASS + 1);
  localparam logic [CW-1:0] LAST = CW'(NPASS);

  logic            busy;
  logic [CW-1:0]   cnt;
  logic [N*DW-1:0] work_re, work_im;
  logic [N*DW-1:0] st_in_re, st_in_im;
  logic [N*DW-1:0] st_out_re, st_out_im;
  logic [CW-1:0]   st_pass;

  // Input bypass: fresh vector on the first pass, fed-back register afterwards.
  assign st_in_re = busy ? work_re : din_re;
  assign st_in_im = busy ? work_im : din_im;
  assign st_pass  = busy ? cnt : '0;

  cg_stage #(.N(N), .DW(DW), .CW(CW)) u_stage (
    .pass (st_pass),
    .x_re (st_in_re),
    .x_im (st_in_im),
    .y_re (st_out_re),
    .y_im (st_out_im)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      cnt     <= '0;
      done    <= 1'b0;
      work_re <= '0;
      work_im <= '0;
      dout_re <= '0;
      dout_im <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          work_re <= st_out_re;
          work_im <= st_out_im;
          cnt     <= CW'(1);
          busy    <= 1'b1;
        end
      end else if (cnt != LAST) begin
        work_re <= st_out_re;
        work_im <= st_out_im;
        cnt     <= cnt + 1'b1;
      end else begin
        dout_re <= work_re;
        dout_im <= work_im;
        done    <= 1'b1;
        busy    <= 1'b0;
      end
    end
  end

  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!done && dout_re == '0 && dout_im == '0));

  a_r2_single_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r2_done_after_last_pass: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(busy && cnt == LAST));

  a_r3_pass_advances: assert property (@(posedge clk) disable iff (rst)
    (busy && cnt != LAST) |=> (busy && cnt == CW'($past(cnt) + 1'b1)));

  a_r4_hold_result: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(dout_re) && $stable(dout_im)));

endmodule

// File: tb/fft_cg_core_bench.sv
`timescale 1ns/1ps
module fft_cg_core_bench;
  localparam int N   = 8;
  localparam int DW  = 16;
  localparam int NP  = 3;
  localparam int TOL = 8;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            start = 1'b0;
  logic [N*DW-1:0] din_re = '0;
  logic [N*DW-1:0] din_im = '0;
  logic            done;
  logic [N*DW-1:0] dout_re, dout_im;

  int  total = 0;
  int  bad   = 0;
  int  vr [N];
  int  vi [N];
  real er [N];
  real ei [N];
  logic [N*DW-1:0] hold_re, hold_im;

  always #2.5 clk = ~clk;

  fft_cg_core #(.N(N), .DW(DW)) u_fft_cg_core (
    .clk (clk), .rst (rst), .start (start),
    .din_re (din_re), .din_im (din_im),
    .done (done), .dout_re (dout_re), .dout_im (dout_im)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int bitrev(input int p);
    int r = 0;
    for (int b = 0; b < NP; b++) r |= ((p >> b) & 1) << (NP - 1 - b);
    return r;
  endfunction

  function automatic int lane(input logic [N*DW-1:0] v, input int p);
    return int'($signed(v[p*DW +: DW]));
  endfunction

  task automatic load_vec();
    for (int p = 0; p < N; p++) begin
      din_re[p*DW +: DW] = DW'(vr[p]);
      din_im[p*DW +: DW] = DW'(vi[p]);
    end
    for (int k = 0; k < N; k++) begin
      er[k] = 0.0;
      ei[k] = 0.0;
      for (int n = 0; n < N; n++) begin
        real a;
        a = -6.283185307179586 * real'(n * k) / real'(N);
        er[k] += real'(vr[n]) * $cos(a) - real'(vi[n]) * $sin(a);
        ei[k] += real'(vr[n]) * $sin(a) + real'(vi[n]) * $cos(a);
      end
    end
    start = 1'b1;
  endtask

  task automatic compare(input string req);
    for (int p = 0; p < N; p++) begin
      int k, ar, ai, xr, xi;
      k  = bitrev(p);
      ar = lane(dout_re, p);
      ai = lane(dout_im, p);
      xr = $rtoi(er[k] + (er[k] >= 0.0 ? 0.5 : -0.5));
      xi = $rtoi(ei[k] + (ei[k] >= 0.0 ? 0.5 : -0.5));
      chk((ar - xr <= TOL) && (xr - ar <= TOL), req, $sformatf("re lane %0d", p), ar, xr);
      chk((ai - xi <= TOL) && (xi - ai <= TOL), req, $sformatf("im lane %0d", p), ai, xi);
    end
  endtask

  // One transform; optional start held high with altered data while running.
  task automatic run_one(input bit poke, input string req);
    @(negedge clk);
    load_vec();
    @(negedge clk);
    start = poke;
    if (poke) begin
      din_re = ~din_re;
      din_im = din_im ^ {N{16'h5a5a}};
    end
    chk(done == 1'b0, "R2", "done early", int'(done), 0);
    for (int i = 0; i < NP - 1; i++) begin
      @(negedge clk);
      chk(done == 1'b0, "R2", "done early", int'(done), 0);
    end
    @(negedge clk);
    start = 1'b0;
    chk(done == 1'b1, "R2", "done at latency", int'(done), 1);
    compare(poke ? "R3" : req);
    hold_re = dout_re;
    hold_im = dout_im;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(done == 1'b0, "R2", "done pulse width", int'(done), 0);
      chk(dout_re == hold_re && dout_im == hold_im, "R4", "output held",
          lane(dout_re, 0), lane(hold_re, 0));
    end
  endtask

  task automatic rand_vec(input int amp);
    for (int p = 0; p < N; p++) begin
      vr[p] = int'($urandom_range(2 * amp, 0)) - amp;
      vi[p] = int'($urandom_range(2 * amp, 0)) - amp;
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(done == 1'b0, "R1", "done in reset", int'(done), 0);
    chk(dout_re == '0 && dout_im == '0, "R1", "outputs in reset", lane(dout_re, 0), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(done == 1'b0, "R1", "done after reset", int'(done), 0);
    chk(dout_re == '0 && dout_im == '0, "R1", "outputs after reset", lane(dout_re, 0), 0);

    // R7: exact flat spectrum from a lane-0 impulse.
    for (int s = 0; s < 2; s++) begin
      int amp = (s == 0) ? 16000 : -12345;
      for (int p = 0; p < N; p++) begin vr[p] = 0; vi[p] = 0; end
      vr[0] = amp;
      run_one(1'b0, "R7");
      for (int p = 0; p < N; p++) begin
        chk(lane(dout_re, p) == amp, "R7", $sformatf("re lane %0d", p), lane(dout_re, p), amp);
        chk(lane(dout_im, p) == 0, "R7", $sformatf("im lane %0d", p), lane(dout_im, p), 0);
      end
    end

    // R5: impulses at every lane, real and imaginary.
    for (int q = 0; q < N; q++) begin
      for (int p = 0; p < N; p++) begin vr[p] = 0; vi[p] = 0; end
      vr[q] = 1500;
      vi[(q + 3) % N] = -900;
      run_one(1'b0, "R5");
    end
    // R5: constant vector.
    for (int p = 0; p < N; p++) begin vr[p] = 1700; vi[p] = -400; end
    run_one(1'b0, "R5");
    // R5: cosine at bin 1.
    for (int p = 0; p < N; p++) begin
      vr[p] = $rtoi(1800.0 * $cos(6.283185307179586 * real'(p) / real'(N)));
      vi[p] = 0;
    end
    run_one(1'b0, "R5");
    // R5: alternating sign.
    for (int p = 0; p < N; p++) begin
      vr[p] = (p % 2 == 0) ? 1800 : -1800;
      vi[p] = (p % 2 == 0) ? -1000 : 1000;
    end
    run_one(1'b0, "R5");
    // R5: random sweep.
    for (int t = 0; t < 300; t++) begin
      rand_vec(1800);
      run_one(1'b0, "R5");
    end

    // R3: start held with different data while running.
    for (int t = 0; t < 20; t++) begin
      rand_vec(1800);
      run_one(1'b1, "R3");
    end

    // R6: back-to-back from the done cycle.
    for (int t = 0; t < 10; t++) begin
      rand_vec(1800);
      @(negedge clk);
      load_vec();
      @(negedge clk);
      start = 1'b0;
      repeat (NP - 1) @(negedge clk);
      @(negedge clk);
      chk(done == 1'b1, "R6", "first done", int'(done), 1);
      compare("R6");
      rand_vec(1800);
      load_vec();
      @(negedge clk);
      start = 1'b0;
      chk(done == 1'b0, "R6", "no second done yet", int'(done), 0);
      for (int i = 0; i < NP - 1; i++) begin
        @(negedge clk);
        chk(done == 1'b0, "R6", "chained done early", int'(done), 0);
      end
      @(negedge clk);
      chk(done == 1'b1, "R6", "chained done", int'(done), 1);
      compare("R6");
      @(negedge clk);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule